// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Mode Controller

This block is the control front end of a CAN receive acceptance filter. It holds the filter's operating mode and five section boundary registers. The boundaries are word offsets into a 512-word identifier table that an external search engine walks. Software reaches all of this state through a simple word-wide register bus. The block decides what happens to each received frame: it drops the frame, it accepts the frame without filtering, or it defers to the match result from the search engine. It also holds that engine in reset while filtering is not active.

The mode register has three bits. Bit 0 (`off`) shuts the filter down. Bit 1 (`bypass`) accepts all frames. Bit 2 (`fullcan`) is an enable that passes straight through to message storage logic elsewhere. The section boundaries may only change while the filter is shut down or bypassed, so the search engine never sees a table layout change under it. A hardware request line can force the filter off at any time, and it takes precedence over software.

Register map (word index on `bus_addr`): 0 is the mode register. 1 to 5 are section boundaries 0 to 4. Every other index is unmapped.

Top module: `afilt_mode_ctrl`

## Requirements
- R1: After reset the mode register reads 0x1 (off=1, bypass=0, fullcan=0), all five section registers read 0, and `engine_halt` is 1.
- R2: A write to index 0 loads bits 2:0 of the write data into the mode register as {fullcan, bypass, off}. Bits 31:3 of the mode register read as 0 whatever was written.
- R3: When `force_off` is 1 in a cycle, the off bit is 1 after that edge, even if a software write clearing the off bit occurs in the same cycle.
- R4: A write to index 1..5 while off=1 or bypass=1 stores the low 10 bits of the write data in the matching section register.
- R5: A write to index 1..5 while off=0 and bypass=0 leaves every section register unchanged and signals nothing.
- R6: Section registers keep only 10 bits, and bits 31:10 of any read data are 0.
- R7: `rx_accept` is 0 while off=1 and bypass=0, whatever `search_hit` is.
- R8: `rx_accept` equals `rx_valid` while bypass=1, whatever the off bit is.
- R9: While off=0 and bypass=0, `rx_accept` equals `rx_valid` AND `search_hit`. When `rx_valid` is 0, `rx_accept` is 0 in every mode.
- R10: `engine_halt` is 1 exactly when off=1 or bypass=1.
- R11: A read strobe captures the addressed register into `bus_rdata` at the next edge, and `bus_rdata` holds until the next strobe. Reads work in every mode, and unmapped indices read 0.
- R12: `sec_bounds` presents section register k on bits [10k+9:10k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| force_off | input | 1 | Hardware request to set the off bit |
| rx_valid | input | 1 | A received frame is presented this cycle |
| search_hit | input | 1 | Match result from the external search engine |
| rx_accept | output | 1 | Frame accepted (combinational) |
| engine_halt | output | 1 | Hold the search engine in reset |
| fullcan_en | output | 1 | Enhanced message storage enable |
| sec_bounds | output | 50 | Five 10-bit section boundaries |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never asserted together, and that `bus_addr` and `bus_wdata` are stable for the cycle of a strobe. The checks on the section registers rely on at most one write per cycle. The bench drives each strobe for exactly one cycle from a task. It changes all inputs on the falling edge and never overlaps a read with a write. `force_off` is raised alone, or together with a mode write only in the scenario that tests their priority.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int MODE_BITS = 3;

  // Packed so that bit 0 is off, bit 1 is bypass, bit 2 is fullcan.
  typedef struct packed {
    logic fullcan;
    logic bypass;
    logic off;
  } afilt_mode_t;

  localparam afilt_mode_t MODE_RESET = '{fullcan: 1'b0, bypass: 1'b0, off: 1'b1};

  function automatic logic sections_open(input afilt_mode_t m);
    return m.off | m.bypass;
  endfunction
endpackage

// File: rtl/afilt_mode_reg.sv
module afilt_mode_reg
  import afilt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [MODE_BITS-1:0] wr_bits,
  input  logic                 force_off,
  output afilt_mode_t          mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
    end else begin
      if (wr_en)
        mode_q <= afilt_mode_t'(wr_bits);
      if (force_off)
        mode_q.off <= 1'b1;
    end
  end

  // R3
  force_off_chk: assert property (@(posedge clk) disable iff (rst)
    force_off |=> mode_q.off);

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !force_off) |=> (mode_q == afilt_mode_t'($past(wr_bits))));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !force_off) |=> $stable(mode_q));

endmodule

// File: rtl/afilt_section_bank.sv
module afilt_section_bank #(
  parameter int NUM_SEC = 5,
  parameter int SEC_W   = 10,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [SEC_W-1:0]         wr_val,
  input  logic                     wr_open,
  output logic [NUM_SEC*SEC_W-1:0] sec_flat
);

  logic [SEC_W-1:0] sec_q [NUM_SEC];

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    always_ff @(posedge clk) begin
      if (rst)
        sec_q[g] <= '0;
      else if (wr_en && wr_open && (wr_idx == IDX_W'(g)))
        sec_q[g] <= wr_val;
    end

    assign sec_flat[g*SEC_W +: SEC_W] = sec_q[g];

    // R4
    sec_store_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_open && (wr_idx == IDX_W'(g))) |=> (sec_flat[g*SEC_W +: SEC_W] == $past(wr_val)));
  end

  // R5
  blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_open) |=> $stable(sec_flat));

endmodule

// File: rtl/afilt_accept_gate.sv
module afilt_accept_gate (
  input  logic clk,
  input  logic rst,
  input  logic off,
  input  logic bypass,
  input  logic rx_valid,
  input  logic search_hit,
  output logic rx_accept,
  output logic engine_halt
);

  always_comb begin
    if (!rx_valid)
      rx_accept = 1'b0;
    else if (bypass)
      rx_accept = 1'b1;
    else if (off)
      rx_accept = 1'b0;
    else
      rx_accept = search_hit;
  end

  assign engine_halt = off | bypass;

  // R7
  off_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (off && !bypass) |-> !rx_accept);

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass && rx_valid) |-> rx_accept);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> !rx_accept);

endmodule

// File: rtl/afilt_mode_ctrl.sv
module afilt_mode_ctrl
  import afilt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int NUM_SEC = 5,
  parameter int SEC_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     force_off,
  input  logic                     rx_valid,
  input  logic                     search_hit,
  output logic                     rx_accept,
  output logic                     engine_halt,
  output logic                     fullcan_en,
  output logic [NUM_SEC*SEC_W-1:0] sec_bounds
);

  localparam int IDX_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1;

  afilt_mode_t            mode_q;
  logic                   mode_sel;
  logic                   sec_sel;
  logic [ADDR_W-1:0]      sec_off;
  logic [IDX_W-1:0]       sec_idx;
  logic [DATA_W-1:0]      rd_word;
  logic                   unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:SEC_W];

  assign mode_sel = (bus_addr == '0);
  assign sec_sel  = (bus_addr != '0) && (bus_addr <= ADDR_W'(NUM_SEC));
  assign sec_off  = bus_addr - ADDR_W'(1);
  assign sec_idx  = sec_off[IDX_W-1:0];

  afilt_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr && mode_sel),
    .wr_bits  (bus_wdata[MODE_BITS-1:0]),
    .force_off(force_off),
    .mode_q   (mode_q)
  );

  afilt_section_bank #(
    .NUM_SEC(NUM_SEC),
    .SEC_W  (SEC_W),
    .IDX_W  (IDX_W)
  ) u_sec (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && sec_sel),
    .wr_idx  (sec_idx),
    .wr_val  (bus_wdata[SEC_W-1:0]),
    .wr_open (sections_open(mode_q)),
    .sec_flat(sec_bounds)
  );

  afilt_accept_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .off        (mode_q.off),
    .bypass     (mode_q.bypass),
    .rx_valid   (rx_valid),
    .search_hit (search_hit),
    .rx_accept  (rx_accept),
    .engine_halt(engine_halt)
  );

  assign fullcan_en = mode_q.fullcan;

  always_comb begin
    rd_word = '0;
    if (mode_sel)
      rd_word[MODE_BITS-1:0] = mode_q;
    else if (sec_sel)
      rd_word[SEC_W-1:0] = sec_bounds[int'(sec_idx)*SEC_W +: SEC_W];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_word;
  end

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr > ADDR_W'(NUM_SEC))) |=> (bus_rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R6
  rdata_upper_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:SEC_W] == '0);

  // R10
  halt_track_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && mode_sel && !force_off && (bus_wdata[1:0] == 2'b00)) |=> !engine_halt);

endmodule

// File: tb/afilt_mode_ctrl_test.sv
module afilt_mode_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        force_off;
  logic        rx_valid;
  logic        search_hit;
  logic        rx_accept;
  logic        engine_halt;
  logic        fullcan_en;
  logic [49:0] sec_bounds;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  afilt_mode_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .force_off(force_off),
    .rx_valid(rx_valid), .search_hit(search_hit), .rx_accept(rx_accept),
    .engine_halt(engine_halt), .fullcan_en(fullcan_en), .sec_bounds(sec_bounds)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic probe(input logic v, input logic h, input logic exp, input string req);
    rx_valid = v; search_hit = h;
    #1;
    check(req, {31'd0, rx_accept}, {31'd0, exp});
    rx_valid = 1'b0; search_hit = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(3'd0, d);
    check("R1 mode", d, 32'h1);
    for (int i = 1; i <= 5; i++) begin
      bus_read(3'(i), d);
      check("R1 section", d, 32'h0);
    end
    check("R1 halt", {31'd0, engine_halt}, 32'd1);
    probe(1'b1, 1'b1, 1'b0, "R7 off drops");
  endtask

  task automatic t_mode_write();
    logic [31:0] d;
    bus_write(3'd0, 32'hFFFF_FFFE);
    bus_read(3'd0, d);
    check("R2 mode bits", d, 32'h6);
    check("R2 fullcan", {31'd0, fullcan_en}, 32'd1);
    check("R10 halt bypass", {31'd0, engine_halt}, 32'd1);
    probe(1'b1, 1'b0, 1'b1, "R8 bypass accepts");
  endtask

  task automatic t_sections_open();
    logic [31:0] d;
    for (int i = 1; i <= 5; i++)
      bus_write(3'(i), 32'hABC0_0000 | (32'h3F1 + 32'(i)));
    for (int i = 1; i <= 5; i++) begin
      bus_read(3'(i), d);
      check("R4 R6 section store", d, (32'h3F1 + 32'(i)) & 32'h3FF);
      check("R12 bound output", {22'd0, sec_bounds[(i-1)*10 +: 10]}, (32'h3F1 + 32'(i)) & 32'h3FF);
    end
  endtask

  task automatic t_filter_mode();
    logic [31:0] d;
    bus_write(3'd0, 32'h0);
    check("R10 halt filter", {31'd0, engine_halt}, 32'd0);
    bus_write(3'd2, 32'h055);
    bus_read(3'd2, d);
    check("R5 blocked write", d, 32'h3F3);
    check("R5 bound unchanged", {22'd0, sec_bounds[19:10]}, 32'h3F3);
    probe(1'b1, 1'b1, 1'b1, "R9 hit");
    probe(1'b1, 1'b0, 1'b0, "R9 miss");
    probe(1'b0, 1'b1, 1'b0, "R9 no valid");
    bus_read(3'd5, d);
    check("R11 read in filter mode", d, 32'h3F6);
  endtask

  task automatic t_off_modes();
    logic [31:0] d;
    bus_write(3'd0, 32'h1);
    probe(1'b1, 1'b1, 1'b0, "R7 off ignores hit");
    bus_write(3'd3, 32'h123);
    bus_read(3'd3, d);
    check("R4 write while off", d, 32'h123);
    bus_write(3'd0, 32'h3);
    probe(1'b1, 1'b0, 1'b1, "R8 off plus bypass");
  endtask

  task automatic t_force();
    logic [31:0] d;
    bus_write(3'd0, 32'h0);
    @(negedge clk);
    force_off = 1'b1;
    @(negedge clk);
    force_off = 1'b0;
    bus_read(3'd0, d);
    check("R3 force alone", d, 32'h1);
    bus_write(3'd0, 32'h0);
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 32'h4; bus_wr = 1'b1; force_off = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; force_off = 1'b0;
    bus_read(3'd0, d);
    check("R3 force beats write", d, 32'h5);
  endtask

  task automatic t_read_path();
    logic [31:0] d;
    bus_read(3'd7, d);
    check("R11 unmapped", d, 32'h0);
    bus_read(3'd6, d);
    check("R11 unmapped 6", d, 32'h0);
    bus_read(3'd0, d);
    repeat (3) @(negedge clk);
    check("R11 hold", bus_rdata, 32'h5);
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    force_off = 1'b0; rx_valid = 1'b0; search_hit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode_write();
    t_sections_open();
    t_filter_mode();
    t_off_modes();
    t_force();
    t_read_path();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule